// File: doc/BRIEF.md
# Memory ECC Fault Injector

This block sits on the write path of a memory controller, just ahead of the ECC encoder. It corrupts the word on its way to storage when an access matches an address pattern that software has set up. The pattern has six fields: DIMM index within its channel, rank, channel, bank, page and column. Each field has its own "match anything" flag, so a pattern can be as narrow as one column of one bank or as wide as every access.

On a match, a bit-flip mask is XORed onto one or both halves of the data word, and the parity bit of each affected half can be inverted. A section select picks the halves. A type field picks data corruption, parity corruption or both, and whether injection repeats or fires only once.

The corrupted word leaves in the same cycle it arrives, so no latency is added to the write path. Every setting can be read back through the same small register port. That port also shows whether the unit is armed and whether an injection has happened.

Top module: `ecc_fault_inject`

## Requirements
- R1: After reset, the six match registers (offsets 0 to 5: DIMM, rank, channel, bank, page, column) read back with bit 31 set, which is the wildcard flag, and value 0. The mask (offset 6), section (offset 7), type (offset 8) and status (offset 9) registers read back as 0.
- R2: A write to any configuration register reads back immediately through `cfg_rdata`. Match registers keep bit 31 and their low field-width bits. The section register keeps 2 bits and the type register keeps 3 bits.
- R3: A match register with bit 31 clear accepts only an access whose field equals the stored value. With bit 31 set it accepts any value. An injection needs all six fields to accept.
- R4: Writing any non-zero value to offset 9 arms the unit, and writing zero disarms it. Either write clears the done flag. Status reads as bit 0 = armed, bit 1 = done. An unarmed unit never injects.
- R5: Only accesses with `acc_valid` and `acc_write` both high can trigger an injection. A matching read passes through unchanged and leaves the status unchanged.
- R6: Section value 1 selects the lower half of the data word (bits 31:0) and parity bit 0. Value 2 selects the upper half (bits 63:32) and parity bit 1. Value 3 selects both halves. Value 0 makes no injection even when armed.
- R7: Type bit 1 XORs the mask onto each selected data half. Type bit 2 inverts the parity bit of each selected half. With neither bit set, nothing is injected.
- R8: The corrupted word, the corrupted parity and `inj_hit` appear in the same cycle as the matching access.
- R9: With type bit 0 clear, the first injection disarms the unit and sets done. Later matching writes pass through unchanged.
- R10: With type bit 0 set, the unit stays armed and corrupts every matching write. Done is set after the first injection.
- R11: When `inj_hit` is low, `out_data` equals `acc_data` and `out_par` equals `acc_par`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational on `cfg_addr` |
| acc_valid | input | 1 | Access present on the bus this cycle |
| acc_write | input | 1 | Access is a write |
| acc_dimm | input | DIMM_W | DIMM index within its channel |
| acc_rank | input | RANK_W | Rank |
| acc_chan | input | CHAN_W | Channel |
| acc_bank | input | BANK_W | Bank |
| acc_page | input | PAGE_W | Page (row) address |
| acc_col | input | COL_W | Column address |
| acc_data | input | DATA_W | Data word entering the encoder path |
| acc_par | input | 2 | One parity bit per data half |
| out_data | output | DATA_W | Data word after injection |
| out_par | output | 2 | Parity after injection |
| inj_hit | output | 1 | An injection is applied this cycle |

## Verification
`inj_hit`, `out_data` and `out_par` are combinational, so they are due in the same cycle as the access that causes them. The bench drives each access on a falling edge and samples these outputs 1 ns later, before the next rising edge. The armed and done flags change on the rising edge that samples the matching write. The bench therefore reads status only after that edge has passed and the access has been removed. Register readback is combinational on the offset and is sampled the same way, one nanosecond after the offset is driven.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    localparam int CFG_W      = 32;
    localparam int ANY_BIT    = 31;
    localparam int NUM_FIELDS = 6;
    localparam int NUM_HALVES = 2;

    typedef enum logic [3:0] {
        SEL_DIMM = 4'd0,
        SEL_RANK = 4'd1,
        SEL_CHAN = 4'd2,
        SEL_BANK = 4'd3,
        SEL_PAGE = 4'd4,
        SEL_COL  = 4'd5,
        SEL_MASK = 4'd6,
        SEL_SECT = 4'd7,
        SEL_TYPE = 4'd8,
        SEL_ARM  = 4'd9
    } cfg_sel_e;

    // packed msb first: par_en is type bit 2, rep_en is bit 0
    typedef struct packed {
        logic par_en;
        logic ecc_en;
        logic rep_en;
    } inj_type_t;

    typedef struct packed {
        logic done;
        logic armed;
    } inj_stat_t;

    function automatic logic field_ok(input logic any, input logic [CFG_W-1:0] want,
                                      input logic [CFG_W-1:0] got);
        return any || (want == got);
    endfunction

endpackage

// File: rtl/inj_regs.sv
module inj_regs
    import ecc_inj_pkg::*;
#(
    parameter int DIMM_W = 2,
    parameter int RANK_W = 2,
    parameter int CHAN_W = 2,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 16,
    parameter int COL_W  = 10,
    parameter int MASK_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [3:0]            cfg_addr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output logic [CFG_W-1:0]      cfg_rdata,
    input  logic                  fire,
    output logic [NUM_FIELDS-1:0] any_q,
    output logic [DIMM_W-1:0]     dimm_q,
    output logic [RANK_W-1:0]     rank_q,
    output logic [CHAN_W-1:0]     chan_q,
    output logic [BANK_W-1:0]     bank_q,
    output logic [PAGE_W-1:0]     page_q,
    output logic [COL_W-1:0]      col_q,
    output logic [MASK_W-1:0]     mask_q,
    output logic [1:0]            sect_q,
    output inj_type_t             type_q,
    output inj_stat_t             stat_q
);
    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            any_q  <= '1;
            dimm_q <= '0;
            rank_q <= '0;
            chan_q <= '0;
            bank_q <= '0;
            page_q <= '0;
            col_q  <= '0;
            mask_q <= '0;
            sect_q <= '0;
            type_q <= '0;
        end else if (cfg_we) begin
            case (sel)
                SEL_DIMM: begin any_q[0] <= cfg_wdata[ANY_BIT]; dimm_q <= cfg_wdata[DIMM_W-1:0]; end
                SEL_RANK: begin any_q[1] <= cfg_wdata[ANY_BIT]; rank_q <= cfg_wdata[RANK_W-1:0]; end
                SEL_CHAN: begin any_q[2] <= cfg_wdata[ANY_BIT]; chan_q <= cfg_wdata[CHAN_W-1:0]; end
                SEL_BANK: begin any_q[3] <= cfg_wdata[ANY_BIT]; bank_q <= cfg_wdata[BANK_W-1:0]; end
                SEL_PAGE: begin any_q[4] <= cfg_wdata[ANY_BIT]; page_q <= cfg_wdata[PAGE_W-1:0]; end
                SEL_COL:  begin any_q[5] <= cfg_wdata[ANY_BIT]; col_q  <= cfg_wdata[COL_W-1:0];  end
                SEL_MASK: mask_q <= cfg_wdata[MASK_W-1:0];
                SEL_SECT: sect_q <= cfg_wdata[1:0];
                SEL_TYPE: type_q <= inj_type_t'(cfg_wdata[2:0]);
                default:  ;
            endcase
        end
    end

    // arm / done state: a register write to the arm offset takes priority over an injection
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (cfg_we && sel == SEL_ARM) begin
            stat_q.armed <= |cfg_wdata;
            stat_q.done  <= 1'b0;
        end else if (fire) begin
            stat_q.done <= 1'b1;
            if (!type_q.rep_en) stat_q.armed <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (sel)
            SEL_DIMM: begin cfg_rdata[ANY_BIT] = any_q[0]; cfg_rdata[DIMM_W-1:0] = dimm_q; end
            SEL_RANK: begin cfg_rdata[ANY_BIT] = any_q[1]; cfg_rdata[RANK_W-1:0] = rank_q; end
            SEL_CHAN: begin cfg_rdata[ANY_BIT] = any_q[2]; cfg_rdata[CHAN_W-1:0] = chan_q; end
            SEL_BANK: begin cfg_rdata[ANY_BIT] = any_q[3]; cfg_rdata[BANK_W-1:0] = bank_q; end
            SEL_PAGE: begin cfg_rdata[ANY_BIT] = any_q[4]; cfg_rdata[PAGE_W-1:0] = page_q; end
            SEL_COL:  begin cfg_rdata[ANY_BIT] = any_q[5]; cfg_rdata[COL_W-1:0]  = col_q;  end
            SEL_MASK: cfg_rdata[MASK_W-1:0] = mask_q;
            SEL_SECT: cfg_rdata[1:0] = sect_q;
            SEL_TYPE: cfg_rdata[2:0] = type_q;
            SEL_ARM:  cfg_rdata[1:0] = stat_q;
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/inj_match.sv
module inj_match
    import ecc_inj_pkg::*;
#(
    parameter int DIMM_W = 2,
    parameter int RANK_W = 2,
    parameter int CHAN_W = 2,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 16,
    parameter int COL_W  = 10
) (
    input  logic [NUM_FIELDS-1:0] any_q,
    input  logic [DIMM_W-1:0]     dimm_q,
    input  logic [RANK_W-1:0]     rank_q,
    input  logic [CHAN_W-1:0]     chan_q,
    input  logic [BANK_W-1:0]     bank_q,
    input  logic [PAGE_W-1:0]     page_q,
    input  logic [COL_W-1:0]      col_q,
    input  logic [DIMM_W-1:0]     acc_dimm,
    input  logic [RANK_W-1:0]     acc_rank,
    input  logic [CHAN_W-1:0]     acc_chan,
    input  logic [BANK_W-1:0]     acc_bank,
    input  logic [PAGE_W-1:0]     acc_page,
    input  logic [COL_W-1:0]      acc_col,
    output logic                  addr_hit
);
    logic [NUM_FIELDS-1:0] ok;

    always_comb begin
        ok[0] = field_ok(any_q[0], CFG_W'(dimm_q), CFG_W'(acc_dimm));
        ok[1] = field_ok(any_q[1], CFG_W'(rank_q), CFG_W'(acc_rank));
        ok[2] = field_ok(any_q[2], CFG_W'(chan_q), CFG_W'(acc_chan));
        ok[3] = field_ok(any_q[3], CFG_W'(bank_q), CFG_W'(acc_bank));
        ok[4] = field_ok(any_q[4], CFG_W'(page_q), CFG_W'(acc_page));
        ok[5] = field_ok(any_q[5], CFG_W'(col_q),  CFG_W'(acc_col));
    end

    assign addr_hit = &ok;

endmodule

// File: rtl/inj_apply.sv
module inj_apply
    import ecc_inj_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int HALF_W = DATA_W / NUM_HALVES
) (
    input  logic                  fire,
    input  logic [NUM_HALVES-1:0] sect_q,
    input  inj_type_t             type_q,
    input  logic [HALF_W-1:0]     mask_q,
    input  logic [DATA_W-1:0]     acc_data,
    input  logic [NUM_HALVES-1:0] acc_par,
    output logic [DATA_W-1:0]     out_data,
    output logic [NUM_HALVES-1:0] out_par
);
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic sel_h;
        assign sel_h = fire && sect_q[h];
        assign out_data[h*HALF_W +: HALF_W] =
            acc_data[h*HALF_W +: HALF_W] ^ ((sel_h && type_q.ecc_en) ? mask_q : '0);
        assign out_par[h] = acc_par[h] ^ (sel_h && type_q.par_en);
    end

endmodule

// File: rtl/ecc_fault_inject.sv
module ecc_fault_inject
    import ecc_inj_pkg::*;
#(
    parameter int DIMM_W       = 2,
    parameter int RANK_W       = 2,
    parameter int CHAN_W       = 2,
    parameter int BANK_W       = 3,
    parameter int PAGE_W       = 16,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 64,
    parameter bit TRIG_ON_READ = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [3:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [DIMM_W-1:0]     acc_dimm,
    input  logic [RANK_W-1:0]     acc_rank,
    input  logic [CHAN_W-1:0]     acc_chan,
    input  logic [BANK_W-1:0]     acc_bank,
    input  logic [PAGE_W-1:0]     acc_page,
    input  logic [COL_W-1:0]      acc_col,
    input  logic [DATA_W-1:0]     acc_data,
    input  logic [1:0]            acc_par,
    output logic [DATA_W-1:0]     out_data,
    output logic [1:0]            out_par,
    output logic                  inj_hit
);
    localparam int HALF_W = DATA_W / NUM_HALVES;

    logic [NUM_FIELDS-1:0] any_q;
    logic [DIMM_W-1:0]     dimm_q;
    logic [RANK_W-1:0]     rank_q;
    logic [CHAN_W-1:0]     chan_q;
    logic [BANK_W-1:0]     bank_q;
    logic [PAGE_W-1:0]     page_q;
    logic [COL_W-1:0]      col_q;
    logic [HALF_W-1:0]     mask_q;
    logic [1:0]            sect_q;
    inj_type_t             type_q;
    inj_stat_t             stat_q;
    logic                  addr_hit;
    logic                  fire;

    inj_regs #(
        .DIMM_W(DIMM_W), .RANK_W(RANK_W), .CHAN_W(CHAN_W),
        .BANK_W(BANK_W), .PAGE_W(PAGE_W), .COL_W(COL_W), .MASK_W(HALF_W)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fire(fire),
        .any_q(any_q), .dimm_q(dimm_q), .rank_q(rank_q), .chan_q(chan_q),
        .bank_q(bank_q), .page_q(page_q), .col_q(col_q), .mask_q(mask_q),
        .sect_q(sect_q), .type_q(type_q), .stat_q(stat_q)
    );

    inj_match #(
        .DIMM_W(DIMM_W), .RANK_W(RANK_W), .CHAN_W(CHAN_W),
        .BANK_W(BANK_W), .PAGE_W(PAGE_W), .COL_W(COL_W)
    ) u_match (
        .any_q(any_q), .dimm_q(dimm_q), .rank_q(rank_q), .chan_q(chan_q),
        .bank_q(bank_q), .page_q(page_q), .col_q(col_q),
        .acc_dimm(acc_dimm), .acc_rank(acc_rank), .acc_chan(acc_chan),
        .acc_bank(acc_bank), .acc_page(acc_page), .acc_col(acc_col),
        .addr_hit(addr_hit)
    );

    assign fire = stat_q.armed && addr_hit && acc_valid
               && (acc_write || TRIG_ON_READ)
               && (sect_q != 2'b00)
               && (type_q.ecc_en || type_q.par_en);

    inj_apply #(.DATA_W(DATA_W)) u_apply (
        .fire(fire), .sect_q(sect_q), .type_q(type_q), .mask_q(mask_q),
        .acc_data(acc_data), .acc_par(acc_par),
        .out_data(out_data), .out_par(out_par)
    );

    assign inj_hit = fire;

endmodule

// File: rtl/ecc_fault_inject_chk.sv
module ecc_fault_inject_chk #(
    parameter int DATA_W       = 64,
    parameter bit TRIG_ON_READ = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [3:0]        cfg_addr,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [DATA_W-1:0] acc_data,
    input logic [1:0]        acc_par,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        out_par,
    input logic              inj_hit,
    input logic              armed,
    input logic              done,
    input logic              rep,
    input logic [1:0]        sect
);
    logic arm_wr;
    assign arm_wr = cfg_we && (cfg_addr == 4'd9);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!armed && !done));

    p_hit_needs_arm_r4: assert property (@(posedge clk) disable iff (rst)
        inj_hit |-> armed);

    p_hit_needs_write_r5: assert property (@(posedge clk) disable iff (rst)
        inj_hit |-> (acc_valid && (acc_write || TRIG_ON_READ)));

    p_sect_zero_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (sect == 2'b00) |-> !inj_hit);

    p_oneshot_disarm_r9: assert property (@(posedge clk) disable iff (rst)
        (inj_hit && !rep && !arm_wr) |=> (!armed && done));

    p_repeat_stays_r10: assert property (@(posedge clk) disable iff (rst)
        (inj_hit && rep && !arm_wr) |=> (armed && done));

    p_passthru_r11: assert property (@(posedge clk) disable iff (rst)
        !inj_hit |-> (out_data == acc_data && out_par == acc_par));

endmodule

bind ecc_fault_inject ecc_fault_inject_chk #(
    .DATA_W(DATA_W), .TRIG_ON_READ(TRIG_ON_READ)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_data(acc_data),
    .acc_par(acc_par), .out_data(out_data), .out_par(out_par),
    .inj_hit(inj_hit), .armed(stat_q.armed), .done(stat_q.done),
    .rep(type_q.rep_en), .sect(sect_q)
);

// File: tb/sim_ecc_fault_inject.sv
`timescale 1ns/1ps
module sim_ecc_fault_inject;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        acc_valid, acc_write;
    logic [1:0]  acc_dimm, acc_rank, acc_chan;
    logic [2:0]  acc_bank;
    logic [15:0] acc_page;
    logic [9:0]  acc_col;
    logic [63:0] acc_data, out_data;
    logic [1:0]  acc_par, out_par;
    logic        inj_hit;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ecc_fault_inject u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_dimm(acc_dimm),
        .acc_rank(acc_rank), .acc_chan(acc_chan), .acc_bank(acc_bank),
        .acc_page(acc_page), .acc_col(acc_col), .acc_data(acc_data),
        .acc_par(acc_par), .out_data(out_data), .out_par(out_par),
        .inj_hit(inj_hit)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_dimm = '0; acc_rank = '0;
        acc_chan = '0; acc_bank = '0; acc_page = '0; acc_col = '0;
        acc_data = '0; acc_par = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1 check(req, {32'h0, cfg_rdata}, {32'h0, exp});
    endtask

    // drive one access at the falling edge and check the same-cycle outputs
    task automatic acc_chk(input string req, input logic wr, input logic [1:0] ch,
                           input logic [15:0] pg, input logic [63:0] d, input logic [1:0] p,
                           input logic [63:0] exp_d, input logic [1:0] exp_p, input logic exp_hit);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_chan = ch; acc_page = pg;
        acc_data = d; acc_par = p;
        #1;
        check({req, " data"}, out_data, exp_d);
        check({req, " par"},  {62'h0, out_par}, {62'h0, exp_p});
        check({req, " hit"},  {63'h0, inj_hit}, {63'h0, exp_hit});
    endtask

    task automatic acc_idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        for (int a = 0; a < 6; a++) cfg_chk("R1 match reset", 4'(a), 32'h8000_0000);
        for (int a = 6; a < 10; a++) cfg_chk("R1 ctrl reset", 4'(a), 32'h0);
        acc_chk("R11 idle pass", 1'b1, 2'd1, 16'h0, 64'hDEAD_BEEF_0123_4567, 2'b10,
                64'hDEAD_BEEF_0123_4567, 2'b10, 1'b0);
        acc_idle();
    endtask

    task automatic t_readback();
        do_reset();
        cfg_wr(4'd0, 32'h0000_0003); cfg_chk("R2 dimm", 4'd0, 32'h0000_0003);
        cfg_wr(4'd4, 32'hFFFF_FFFF); cfg_chk("R2 page", 4'd4, 32'h8000_FFFF);
        cfg_wr(4'd5, 32'h0000_0FFF); cfg_chk("R2 col",  4'd5, 32'h0000_03FF);
        cfg_wr(4'd6, 32'hA5A5_5A5A); cfg_chk("R2 mask", 4'd6, 32'hA5A5_5A5A);
        cfg_wr(4'd7, 32'h0000_0007); cfg_chk("R2 sect", 4'd7, 32'h0000_0003);
        cfg_wr(4'd8, 32'h0000_000F); cfg_chk("R2 type", 4'd8, 32'h0000_0007);
    endtask

    task automatic t_wildcard();
        do_reset();
        cfg_wr(4'd2, 32'h0000_0002);
        cfg_wr(4'd8, 32'h3); cfg_wr(4'd7, 32'h1); cfg_wr(4'd6, 32'hFF);
        cfg_wr(4'd9, 32'h1);
        acc_chk("R3 chan miss", 1'b1, 2'd1, 16'h0, 64'h0, 2'b00, 64'h0, 2'b00, 1'b0);
        acc_chk("R3 chan hit",  1'b1, 2'd2, 16'h0, 64'h0, 2'b00, 64'hFF, 2'b00, 1'b1);
        acc_idle();
        cfg_wr(4'd4, 32'h0000_1234);
        acc_chk("R3 page miss", 1'b1, 2'd2, 16'h1235, 64'h0, 2'b00, 64'h0, 2'b00, 1'b0);
        acc_chk("R3 both hit",  1'b1, 2'd2, 16'h1234, 64'h0, 2'b00, 64'hFF, 2'b00, 1'b1);
        acc_idle();
        cfg_wr(4'd2, 32'h8000_0000);
        acc_chk("R3 chan any",  1'b1, 2'd3, 16'h1234, 64'h0, 2'b00, 64'hFF, 2'b00, 1'b1);
        acc_idle();
    endtask

    task automatic t_enable();
        do_reset();
        cfg_wr(4'd8, 32'h3); cfg_wr(4'd7, 32'h1); cfg_wr(4'd6, 32'h1);
        acc_chk("R4 unarmed", 1'b1, 2'd0, 16'h0, 64'h10, 2'b00, 64'h10, 2'b00, 1'b0);
        acc_idle();
        cfg_wr(4'd9, 32'h0000_0080);
        cfg_chk("R4 armed status", 4'd9, 32'h1);
        acc_chk("R4 armed", 1'b1, 2'd0, 16'h0, 64'h10, 2'b00, 64'h11, 2'b00, 1'b1);
        acc_idle();
        cfg_wr(4'd9, 32'h0);
        cfg_chk("R4 disarm status", 4'd9, 32'h0);
        acc_chk("R4 disarmed", 1'b1, 2'd0, 16'h0, 64'h10, 2'b00, 64'h10, 2'b00, 1'b0);
        acc_idle();
    endtask

    task automatic t_read_ignored();
        do_reset();
        cfg_wr(4'd8, 32'h3); cfg_wr(4'd7, 32'h1); cfg_wr(4'd6, 32'h1);
        cfg_wr(4'd9, 32'h1);
        acc_chk("R5 read pass", 1'b0, 2'd0, 16'h0, 64'h20, 2'b01, 64'h20, 2'b01, 1'b0);
        acc_idle();
        cfg_chk("R5 status kept", 4'd9, 32'h1);
    endtask

    task automatic t_section();
        do_reset();
        cfg_wr(4'd8, 32'h3); cfg_wr(4'd6, 32'hF0); cfg_wr(4'd9, 32'h1);
        cfg_wr(4'd7, 32'h1);
        acc_chk("R6 R8 lower", 1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h0000_0000_0000_00F0, 2'b00, 1'b1);
        acc_idle();
        cfg_wr(4'd7, 32'h2);
        acc_chk("R6 R8 upper", 1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h0000_00F0_0000_0000, 2'b00, 1'b1);
        acc_idle();
        cfg_wr(4'd7, 32'h3);
        acc_chk("R6 R8 both",  1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h0000_00F0_0000_00F0, 2'b00, 1'b1);
        acc_idle();
        cfg_wr(4'd7, 32'h0);
        acc_chk("R6 none",     1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h0, 2'b00, 1'b0);
        acc_idle();
    endtask

    task automatic t_type();
        do_reset();
        cfg_wr(4'd6, 32'hF0); cfg_wr(4'd7, 32'h2); cfg_wr(4'd8, 32'h5);
        cfg_wr(4'd9, 32'h1);
        acc_chk("R7 parity only", 1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h0, 2'b10, 1'b1);
        acc_idle();
        cfg_wr(4'd8, 32'h1);
        acc_chk("R7 no kind", 1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h0, 2'b00, 1'b0);
        acc_idle();
        cfg_wr(4'd8, 32'h7); cfg_wr(4'd7, 32'h3);
        acc_chk("R7 data and parity", 1'b1, 2'd0, 16'h0, 64'h0, 2'b00,
                64'h0000_00F0_0000_00F0, 2'b11, 1'b1);
        acc_idle();
    endtask

    task automatic t_oneshot();
        do_reset();
        cfg_wr(4'd8, 32'h2); cfg_wr(4'd7, 32'h1); cfg_wr(4'd6, 32'h1);
        cfg_wr(4'd9, 32'h1);
        acc_chk("R9 first", 1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h1, 2'b00, 1'b1);
        acc_chk("R9 second", 1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h0, 2'b00, 1'b0);
        acc_idle();
        cfg_chk("R9 done status", 4'd9, 32'h2);
        cfg_wr(4'd9, 32'h1);
        cfg_chk("R4 rearm clears done", 4'd9, 32'h1);
    endtask

    task automatic t_repeat();
        do_reset();
        cfg_wr(4'd8, 32'h3); cfg_wr(4'd7, 32'h1); cfg_wr(4'd6, 32'h1);
        cfg_wr(4'd9, 32'h1);
        for (int i = 0; i < 3; i++)
            acc_chk("R10 repeat", 1'b1, 2'd0, 16'h0, 64'h0, 2'b00, 64'h1, 2'b00, 1'b1);
        acc_idle();
        cfg_chk("R10 status", 4'd9, 32'h3);
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_readback();
        t_wildcard();
        t_enable();
        t_read_ignored();
        t_section();
        t_type();
        t_oneshot();
        t_repeat();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule